// File: doc/BRIEF.md
# SDRAM Bank Timing and Refresh Scheduler

This block sits between an upstream memory controller and the SDRAM command pins. The controller presents one command request at a time: open a row, read, write or close a row, each tagged with a bank and a row address. The scheduler keeps a small record per bank: whether a row is open, and how many cycles remain before the bank accepts its next command. It grants a request only in the cycle it becomes legal. The granted command appears on the command outputs in that same cycle. A request that is not yet legal stays pending until it can be granted.

A refresh timer runs alongside the bank records. It raises a refresh demand often enough to spread 8192 auto-refresh operations over each 64 ms window, with the interval derived from the clock frequency. While a refresh is owed, the scheduler holds all upstream requests. It closes any open bank itself and issues the auto-refresh once every bank is idle. After that it blocks all commands for the refresh cycle time. A low clock enable freezes the whole block: timers, state and command issue.

Top module: `sdram_bank_sched`

## Requirements
- R1: After reset no command is issued (`cmd_valid` = 0), no request is granted, and every bank is closed, so an open-row request to any bank is granted at once.
- R2: Request codes are 0 = open row, 1 = read, 2 = write, 3 = close row. Output codes are the same four values plus 4 = auto-refresh. A granted request drives `cmd_valid` = 1 with its code, bank and row on the command outputs in the same cycle as `req_grant`.
- R3: A read or write to a bank is granted no earlier than `T_RCD` enabled cycles after that bank's open-row command.
- R4: An open-row command to a bank is granted no earlier than `T_RP` enabled cycles after that bank's close-row command.
- R5: A bank's pending timer never delays a request to a different bank that is itself ready.
- R6: A refresh demand arises every `REFI` = CLK_KHZ*64/8192 enabled cycles. The scheduler first issues close-row commands, lowest bank number first, to every open bank. It issues auto-refresh only when all banks are closed and their timers have expired.
- R7: After an auto-refresh, no command of any kind is issued for `T_RFC` enabled cycles.
- R8: From the time a refresh is owed until its auto-refresh is issued, no upstream request is granted.
- R9: If `cke` is sampled low at a clock edge, the next edge is ignored. No command is issued in that cycle and no timer advances, so every pending delay grows by one cycle for each low sample.
- R10: A request held back by any rule stays pending and is granted, unchanged, once it becomes legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; a low sample freezes the next cycle |
| req_valid | input | 1 | Upstream request present |
| req_cmd | input | 2 | Request code (0 open, 1 read, 2 write, 3 close) |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Row address |
| req_grant | output | 1 | Request accepted this cycle |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Issued command code (0..4) |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of the issued command |
| cmd_row | output | ROW_W | Row of the issued command |

## Verification
The refresh demand can collide with a stream of upstream requests. It can also collide with the tail of a bank's open-row delay, which forces the scheduler to wait before it can close that bank. The bench provokes this by keeping a request for bank 3 continuously pending across the refresh point while other banks are left open. A monitor then judges the engine's behaviour. It checks that close-row commands reach the open banks before the auto-refresh, that no grant slips in between, that the auto-refresh finds every bank closed, and that the first grant afterwards lands exactly `T_RFC` cycles later.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_REF = 3'd4
  } op_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bank_trk.sv
module bank_trk #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic do_act,
  input  logic do_pre,
  input  logic do_rw,
  output logic is_open,
  output logic ready
);
  localparam int TMAX = sched_pkg::max2(T_RCD, T_RP);
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          open_q, open_d;

  always_comb begin
    tmr_d  = tmr_q;
    open_d = open_q;
    if (do_act) begin
      open_d = 1'b1;
      tmr_d  = TW'(T_RCD - 1);
    end else if (do_pre) begin
      open_d = 1'b0;
      tmr_d  = TW'(T_RP - 1);
    end else if (en && tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      open_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      open_q <= open_d;
    end
  end

  assign is_open = open_q;
  assign ready   = (tmr_q == '0);

  // Checker counters: enabled cycles since the last open / close of this bank
  localparam int SW = $clog2(TMAX + 2);
  logic [SW-1:0] since_act, since_pre;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= SW'(T_RCD);
      since_pre <= SW'(T_RP);
    end else begin
      if (do_act) since_act <= SW'(1);
      else if (en && since_act < SW'(T_RCD)) since_act <= since_act + 1'b1;
      if (do_pre) since_pre <= SW'(1);
      else if (en && since_pre < SW'(T_RP)) since_pre <= since_pre + 1'b1;
    end
  end

  p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    do_rw |-> (since_act == SW'(T_RCD) && open_q));
  p_rp_gap_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    do_act |-> (since_pre == SW'(T_RP) && !open_q));
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> !(do_act || do_pre || do_rw));
endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int REFI = 1953
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic clr,
  output logic pend
);
  localparam int CW = $clog2(REFI + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = en && (cnt_q == CW'(REFI - 1));

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (en) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (clr) pend_d = 1'b0;
    if (wrap) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !clr) |=> pend_q);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pend_q && !wrap) |=> !pend_q);
endmodule

// File: rtl/sdram_bank_sched.sv
module sdram_bank_sched #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int CLK_KHZ   = 250000,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROW_W-1:0] req_row,
  output logic             req_grant,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [BW-1:0]    cmd_bank,
  output logic [ROW_W-1:0] cmd_row
);
  import sched_pkg::*;

  localparam int REFI = (CLK_KHZ * 64) / 8192;
  localparam int FW   = $clog2(T_RFC + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // Clock-enable sample: a low sample freezes the following cycle
  logic adv;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) adv <= 1'b0;
    else         adv <= cke;
  end

  logic [NUM_BANKS-1:0] open_vec, ready_vec, act_vec, pre_vec, rw_vec;
  logic                 ref_pend, ref_issue;
  logic [FW-1:0]        rfc_q, rfc_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      bank_trk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_trk (
        .clk    (clk),
        .rst_ni (rst_ni),
        .en     (adv),
        .do_act (act_vec[gi]),
        .do_pre (pre_vec[gi]),
        .do_rw  (rw_vec[gi]),
        .is_open(open_vec[gi]),
        .ready  (ready_vec[gi])
      );
    end
  endgenerate

  ref_timer #(.REFI(REFI)) u_ref (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (adv),
    .clr    (ref_issue),
    .pend   (ref_pend)
  );

  // Arbitration: refresh engine first, then the upstream request
  logic          quiet, legal, eng_pre;
  logic [BW-1:0] eng_bank;
  logic [NUM_BANKS-1:0] closable;

  assign quiet    = adv && (rfc_q == '0);
  assign closable = open_vec & ready_vec;

  always_comb begin
    eng_bank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (closable[i]) eng_bank = BW'(i);
    end
  end

  assign eng_pre   = quiet && ref_pend && (closable != '0);
  assign ref_issue = quiet && ref_pend && (open_vec == '0) && (&ready_vec);

  always_comb begin
    unique case (req_cmd)
      2'd0:    legal = !open_vec[req_bank] && ready_vec[req_bank];
      2'd1,
      2'd2:    legal = open_vec[req_bank] && ready_vec[req_bank];
      default: legal = ready_vec[req_bank];
    endcase
  end

  assign req_grant = quiet && !ref_pend && req_valid && legal;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_ACT;
    cmd_bank  = req_bank;
    cmd_row   = req_row;
    if (ref_issue) begin
      cmd_valid = 1'b1;
      cmd_op    = OP_REF;
      cmd_bank  = '0;
      cmd_row   = '0;
    end else if (eng_pre) begin
      cmd_valid = 1'b1;
      cmd_op    = OP_PRE;
      cmd_bank  = eng_bank;
      cmd_row   = '0;
    end else if (req_grant) begin
      cmd_valid = 1'b1;
      cmd_op    = {1'b0, req_cmd};
    end
  end

  always_comb begin
    act_vec = '0;
    pre_vec = '0;
    rw_vec  = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_ACT:       act_vec[cmd_bank] = 1'b1;
        OP_PRE:       pre_vec[cmd_bank] = 1'b1;
        OP_RD, OP_WR: rw_vec[cmd_bank]  = 1'b1;
        default:      ;
      endcase
    end
  end

  // Refresh cycle time counter
  always_comb begin
    rfc_d = rfc_q;
    if (ref_issue)                 rfc_d = FW'(T_RFC - 1);
    else if (adv && rfc_q != '0)   rfc_d = rfc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rfc_q <= '0;
    else         rfc_q <= rfc_d;
  end

  // Checker counter: enabled cycles since the last auto-refresh
  localparam int SW = $clog2(T_RFC + 2);
  logic [SW-1:0] since_ref;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) since_ref <= SW'(T_RFC);
    else if (ref_issue) since_ref <= SW'(1);
    else if (adv && since_ref < SW'(T_RFC)) since_ref <= since_ref + 1'b1;
  end

  p_ref_idle_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && cmd_op == OP_REF) |-> (open_vec == '0));
  p_rfc_gap_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_valid |-> (since_ref == SW'(T_RFC)));
  p_hold_on_ref_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ref_pend |-> !req_grant);
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !adv |-> (!cmd_valid && !req_grant));
  p_grant_drives_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_grant |-> (cmd_valid && cmd_bank == req_bank && cmd_op == {1'b0, req_cmd}));
  p_single_cmd_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ref_issue, eng_pre && !ref_issue, req_grant}));
endmodule

// File: tb/sim_sdram_bank_sched.sv
module sim_sdram_bank_sched;
  localparam int NB = 4, RW = 13, TRCD = 3, TRP = 3, TRFC = 10;
  localparam int REFI = (250000 * 64) / 8192;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic req_grant, cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [RW-1:0] cmd_row;

  int total = 0, bad = 0;
  int cyc = 0;
  int ref_seen = 0, ref_cyc = 0, last_ref_edge = -1;
  int eng_pre_cnt = 0, first_grant_gap = -1;
  logic in_prep = 1'b0;
  logic [NB-1:0] model_open = '0;

  always #2 clk = ~clk;

  sdram_bank_sched u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_row(req_row),
    .req_grant(req_grant), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: independent bank model and refresh-engine rules
  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cmd_valid && !req_grant && cmd_op == 3'd3) begin
        in_prep = 1'b1;
        eng_pre_cnt++;
      end
      if (req_grant && in_prep) check(1'b0, "R8 grant during refresh close-out", 1, 0);
      if (req_grant && ref_seen > 0 && first_grant_gap < 0)
        first_grant_gap = cyc - last_ref_edge;
      if (cmd_valid) begin
        case (cmd_op)
          3'd0: model_open[cmd_bank] = 1'b1;
          3'd3: model_open[cmd_bank] = 1'b0;
          3'd4: begin
            check(model_open == '0, "R6 refresh with open bank", model_open, 0);
            if (ref_seen == 0) ref_cyc = cyc;
            ref_seen++;
            last_ref_edge = cyc;
            in_prep = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // Issue one request, count waited cycles; optional clock-enable low window
  task automatic req(input logic [1:0] c, input int b, input int r, input int cke_low,
                     output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = 2'(b); req_row = RW'(r);
    if (cke_low > 0) cke = 1'b0;
    waited = 0;
    forever begin
      #1;
      if (req_grant) begin
        check(cmd_valid && cmd_op == {1'b0, c} && cmd_bank == 2'(b) && cmd_row == RW'(r),
              "R2 command outputs", {cmd_valid, cmd_op}, {1'b1, 1'b0, c});
        break;
      end
      @(negedge clk);
      waited++;
      if (waited == cke_low) cke = 1'b1;
      if (waited > 200) begin
        check(1'b0, "R10 request never granted", waited, 0);
        break;
      end
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    int w;
    #1;
    check(!cmd_valid && !req_grant, "R1 quiet after reset", {cmd_valid, req_grant}, 0);
    req(2'd0, 0, 100, 0, w);
    check(w == 0, "R1 bank closed at reset, open granted at once", w, 0);
  endtask

  task automatic t_rcd();
    int w;
    req(2'd1, 0, 100, 0, w);
    check(w == TRCD - 1, "R3 read after open", w, TRCD - 1);
    req(2'd2, 0, 100, 0, w);
    check(w == 0, "R3 write once delay met", w, 0);
  endtask

  task automatic t_rp_indep();
    int w;
    req(2'd3, 0, 0, 0, w);
    check(w == 0, "R4 close open bank", w, 0);
    req(2'd0, 1, 7, 0, w);
    check(w == 0, "R5 other bank not delayed", w, 0);
    req(2'd0, 0, 55, 0, w);
    check(w == TRP - 2, "R4 reopen after close", w, TRP - 2);
  endtask

  task automatic t_freeze();
    int w;
    req(2'd0, 2, 9, 0, w);
    check(w == 0, "R5 open bank 2", w, 0);
    req(2'd1, 2, 9, 4, w);
    check(w == TRCD - 1 + 4, "R9 clock-enable freeze extends delay", w, TRCD + 3);
    idle();
  endtask

  task automatic t_refresh();
    int w;
    while (ref_seen == 0) begin
      req(2'd0, 3, 1, 0, w);
      req(2'd3, 3, 0, 0, w);
    end
    req(2'd0, 3, 2, 0, w);
    idle();
    repeat (3) @(negedge clk);
    check(ref_seen == 1, "R6 one refresh issued", ref_seen, 1);
    check(ref_cyc >= REFI && ref_cyc <= REFI + 40, "R6 refresh interval", ref_cyc, REFI);
    check(eng_pre_cnt >= 3, "R6 engine closed open banks", eng_pre_cnt, 3);
    check(first_grant_gap == TRFC, "R7 gap after refresh", first_grant_gap, TRFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rcd();
    t_rp_indep();
    t_freeze();
    t_refresh();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    check(1'b0, "R10 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule